// File: doc/BRIEF.md
# Pipelined Burst SRAM with Zero Bus Turnaround

This block is a synchronous single-port static memory whose address, control and write-data paths are all pipelined to the same depth. A read is accepted on one clock edge, and its data comes back two enabled edges later. A write is accepted the same way, and its data is taken from the write-data pins two enabled edges after the address. Because both directions see the same delay, reads and writes can follow each other on every clock with no idle cycle between them.

A short burst is started by a load cycle. On each later advance cycle, a two-bit counter steps the low address bits, in either linear or interleaved order. A single active-low clock enable freezes the whole pipeline.

There is no back-pressure on either data path. Write data has no valid or ready of its own: its slot is fixed by the accepted write address. Read data leaves with a valid flag and no ready. A consumer that cannot take a word holds off the whole block with the clock enable, and while it is held the output word and its flag stay unchanged.

Top module: `pipe_burst_sram`

## Requirements
- R1: While `clk_en_n` is high, every clock edge is ignored. `rd_valid`, `rd_data`, the burst state, the pipeline stages and the array all keep their values, and no byte is written.
- R2: A load cycle (`advance` low, `sel_n` low, `wr_n` high) accepts a read at `addr`. After the second following enabled edge, `rd_valid` is high and `rd_data` holds the word stored at that address.
- R3: A load cycle with `wr_n` low accepts a write. `lane_wr_n` is taken with the address, and lane i covers bits [i*LANE_W +: LANE_W], updated only when `lane_wr_n[i]` is low. `wr_data` is sampled on the second enabled edge after the address.
- R4: Reads and writes may be issued on consecutive enabled cycles in any mix. A read accepted one cycle after a write to the same address returns the new data, merged per lane.
- R5: An advance cycle (`advance` high) after a load repeats the loaded operation type. When `burst_linear` was high at the load, the low two address bits become (base + n) mod 4 for the n-th advance.
- R6: When `burst_linear` was low at the load, the low two address bits of the n-th advance are base XOR (n mod 4). `burst_linear` is taken only on load cycles.
- R7: During a burst, the address bits above the low two never change, and the counter wraps after four words and continues.
- R8: A load cycle with `sel_n` high is a deselect. Two enabled edges later `rd_valid` is low, and any advance cycles that follow stay idle until the next load.
- R9: Reset clears `rd_valid`, the pipeline and the burst state, and keeps the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| advance | input | 1 | High: step the burst; low: load a new cycle |
| wr_n | input | 1 | Active-low write select on load cycles |
| sel_n | input | 1 | Active-low chip select on load cycles |
| lane_wr_n | input | NB | Active-low per-lane write enables |
| addr | input | AW | Word address on load cycles |
| burst_linear | input | 1 | Burst order on load: 1 linear, 0 interleaved |
| wr_data | input | NB*LANE_W | Write data, two enabled edges after the write address |
| rd_data | output | NB*LANE_W | Read data |
| rd_valid | output | 1 | High when `rd_data` carries a completed read |

## Verification
The assertions assume that the clock enable is a clean level at every edge, and that `advance`, `sel_n` and `wr_n` are never unknown on an enabled edge. They also assume that reset is applied only while no write is in flight, because a write caught mid-pipeline is discarded. The stimulus drives every input at the falling edge to a defined value. It keeps addresses inside a preloaded 64-word window so that every read has a known expected word. It flushes the pipeline with deselect cycles before each reset.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/psram_burst.sv
// Address/control stage: turns load and advance cycles into one issued
// operation per enabled clock, registered as pipeline stage 1.
module psram_burst #(
  parameter int AW = 10,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            advance,
  input  logic            wr_n,
  input  logic            sel_n,
  input  logic [NB-1:0]   lane_wr_n,
  input  logic [AW-1:0]   addr,
  input  logic            burst_linear,
  output psram_pkg::op_e  s1_op,
  output logic [AW-1:0]   s1_addr,
  output logic [NB-1:0]   s1_be
);
  import psram_pkg::*;

  logic          act, n_act;
  op_e           btype, n_type, n_op;
  logic [AW-1:0] base, n_base, n_addr;
  logic [1:0]    cnt, n_cnt, step_cnt, lo_next;
  logic          lin, n_lin;

  assign step_cnt = cnt + 2'd1;
  assign lo_next  = lin ? (base[1:0] + step_cnt) : (base[1:0] ^ step_cnt);

  always_comb begin
    n_op   = OP_IDLE;
    n_addr = s1_addr;
    n_act  = act;
    n_type = btype;
    n_base = base;
    n_cnt  = cnt;
    n_lin  = lin;
    if (!advance) begin
      if (!sel_n) begin
        n_op   = wr_n ? OP_RD : OP_WR;
        n_type = n_op;
        n_addr = addr;
        n_base = addr;
        n_cnt  = 2'd0;
        n_lin  = burst_linear;
        n_act  = 1'b1;
      end else begin
        n_act  = 1'b0;
      end
    end else if (act) begin
      n_op   = btype;
      n_cnt  = step_cnt;
      n_addr = {base[AW-1:2], lo_next};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      btype   <= OP_IDLE;
      base    <= '0;
      cnt     <= 2'd0;
      lin     <= 1'b1;
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
    end else if (en) begin
      act     <= n_act;
      btype   <= n_type;
      base    <= n_base;
      cnt     <= n_cnt;
      lin     <= n_lin;
      s1_op   <= n_op;
      s1_addr <= n_addr;
      s1_be   <= ~lane_wr_n;
    end
  end

  // R5: each advance inside a burst steps the counter by exactly one
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && advance && act) |=> (cnt == 2'($past(cnt) + 2'd1)));

  // R7: an advance keeps the upper address bits of the issued operation
  p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && advance && act) |=> (s1_addr[AW-1:2] == $past(base[AW-1:2])));

  // R8: a deselect load issues nothing
  p_desel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !advance && sel_n) |=> (s1_op == OP_IDLE));
endmodule

// File: rtl/psram_array.sv
// Storage: one memory per lane, registered read with a same-edge
// write-to-read forward so a read never returns stale data.
module psram_array #(
  parameter int AW     = 10,
  parameter int NB     = 2,
  parameter int LANE_W = 9
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 rd_req,
  input  logic [AW-1:0]        rd_addr,
  input  logic                 wr_req,
  input  logic [AW-1:0]        wr_addr,
  input  logic [NB-1:0]        wr_be,
  input  logic [NB*LANE_W-1:0] wr_data,
  output logic [NB*LANE_W-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  logic hit;
  assign hit = wr_req && (wr_addr == rd_addr);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] wr_lane;
    assign wr_lane = wr_data[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (en) begin
        if (wr_req && wr_be[g]) mem[wr_addr] <= wr_lane;
        if (rd_req) rd_q[g*LANE_W +: LANE_W] <= (hit && wr_be[g]) ? wr_lane : mem[rd_addr];
      end
    end
  end

  // R4: a full-word write colliding with a read is seen by that read
  p_forward_r4: assert property (@(posedge clk)
    (en && rd_req && wr_req && (rd_addr == wr_addr) && (&wr_be)) |=> (rd_q == $past(wr_data)));
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter int AW     = 10,
  parameter int NB     = 2,
  parameter int LANE_W = 9,
  localparam int DW    = NB * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          advance,
  input  logic          wr_n,
  input  logic          sel_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic [AW-1:0] addr,
  input  logic          burst_linear,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  import psram_pkg::*;

  logic          en;
  op_e           op1, op2;
  logic [AW-1:0] a1, a2;
  logic [NB-1:0] be1, be2;
  logic [DW-1:0] arr_q;

  assign en = !clk_en_n;

  psram_burst #(.AW(AW), .NB(NB)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(en), .advance(advance), .wr_n(wr_n),
    .sel_n(sel_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .burst_linear(burst_linear), .s1_op(op1), .s1_addr(a1), .s1_be(be1)
  );

  psram_array #(.AW(AW), .NB(NB), .LANE_W(LANE_W)) u_array (
    .clk(clk), .en(en),
    .rd_req(op1 == OP_RD), .rd_addr(a1),
    .wr_req(op2 == OP_WR), .wr_addr(a2), .wr_be(be2), .wr_data(wr_data),
    .rd_q(arr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op2      <= OP_IDLE;
      a2       <= '0;
      be2      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (en) begin
      op2      <= op1;
      a2       <= a1;
      be2      <= be1;
      rd_valid <= (op2 == OP_RD);
      rd_data  <= arr_q;
    end
  end

  // R1: a disabled edge leaves the output word and its flag untouched
  p_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rd_valid) && $stable(rd_data)));

  // R8: no valid output unless a read reached the last stage
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op2 != OP_RD) |=> !rd_valid);
endmodule

// File: tb/tb_pipe_burst_sram.sv
module tb_pipe_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, NB = 2, LANE_W = 9, DW = NB * LANE_W;

  logic clk = 1'b0, rst_n = 1'b0, clk_en_n = 1'b1, advance = 1'b0;
  logic wr_n = 1'b1, sel_n = 1'b1, burst_linear = 1'b1;
  logic [NB-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  pipe_burst_sram #(.AW(AW), .NB(NB), .LANE_W(LANE_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] mmem [1 << AW];
  int m1op = 0, m2op = 0;
  logic [AW-1:0] m1a = '0, m2a = '0;
  logic [NB-1:0] m1be = '0, m2be = '0;
  string m1tag = "", m2tag = "";
  bit bact = 0, blin = 1;
  int bop = 0;
  logic [AW-1:0] bbase = '0;
  logic [1:0] bcnt = '0;
  logic last_rv = 1'b0;
  logic [DW-1:0] last_rd = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] burst_lo(input logic [1:0] b, input logic [1:0] n, input bit l);
    return l ? 2'(b + n) : (b ^ n);
  endfunction

  task automatic step(input logic ckn, input logic adv, input logic wn, input logic sn,
                      input logic [NB-1:0] bwn, input logic [AW-1:0] ad,
                      input logic lin, input string tag);
    int nop; logic [AW-1:0] na; string ntag;
    bit exp_rv; logic [DW-1:0] exp_d; string etag;
    clk_en_n = ckn; advance = adv; wr_n = wn; sel_n = sn;
    lane_wr_n = bwn; addr = ad; burst_linear = lin;
    wr_data = DW'($urandom);
    @(posedge clk); @(negedge clk);
    if (!ckn) begin
      if (m2op == 2)
        for (int i = 0; i < NB; i++)
          if (m2be[i]) mmem[m2a][i*LANE_W +: LANE_W] = wr_data[i*LANE_W +: LANE_W];
      exp_rv = (m2op == 1);
      exp_d = mmem[m2a];
      etag = m2tag;
      nop = 0; na = m1a; ntag = "R8";
      if (!adv) begin
        if (!sn) begin
          nop = wn ? 1 : 2; na = ad; bact = 1; bop = nop; bbase = ad; bcnt = 0; blin = lin;
          ntag = wn ? "R2" : "R3";
        end else bact = 0;
      end else if (bact) begin
        bcnt = bcnt + 2'd1;
        nop = bop;
        na = {bbase[AW-1:2], burst_lo(bbase[1:0], bcnt, blin)};
        ntag = blin ? "R5" : "R6";
      end
      if (nop == 1 && m1op == 2 && m1a == na) ntag = "R4";
      if (tag != "") ntag = tag;
      m2op = m1op; m2a = m1a; m2be = m1be; m2tag = m1tag;
      m1op = nop; m1a = na; m1be = ~bwn; m1tag = ntag;
      if (nop == 0) m1tag = "R8";
      chk(rd_valid == exp_rv, exp_rv ? etag : "R8", "rd_valid", DW'(rd_valid), DW'(exp_rv));
      if (exp_rv) chk(rd_data == exp_d, etag, "rd_data", rd_data, exp_d);
    end else begin
      chk(rd_valid == last_rv, "R1", "rd_valid held", DW'(rd_valid), DW'(last_rv));
      chk(rd_data == last_rd, "R1", "rd_data held", rd_data, last_rd);
    end
    last_rv = rd_valid; last_rd = rd_data;
  endtask

  task automatic desel(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 1'b1, '1, '0, 1'b1, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clk_en_n = 1'b0; advance = 1'b0; sel_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m1op = 0; m2op = 0; bact = 0; m1tag = ""; m2tag = "";
    chk(rd_valid == 1'b0, "R9", "rd_valid after reset", DW'(rd_valid), '0);
    last_rv = rd_valid; last_rd = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // preload the 64-word window with linear write bursts
    for (int b = 0; b < 16; b++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, AW'(b*4), 1'b1, "");
      for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1, "");
    end
    desel(2);
    // R2 single read, R5 linear burst, R7 wrap past four words
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd6, 1'b1, "R2");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 1'b1, 1'b0, '1, 10'h3ff, 1'b1, "R7");
    // R6 interleaved burst; burst_linear toggled after load is ignored
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd9, 1'b0, "R6");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1, 1'b0, '1, '0, 1'b1, "R6");
    // R4 back-to-back write/read alternation on the same address
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, AW'(30 + k), 1'b1, "");
      step(1'b0, 1'b0, 1'b1, 1'b0, '1, AW'(30 + k), 1'b1, "R4");
    end
    // R3 partial lane write then read back
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 10'd20, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 10'd21, 1'b1, "R3");
    desel(2);
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd20, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd21, 1'b1, "R3");
    // R1 stall in the middle of reads and writes
    step(1'b0, 1'b0, 1'b0, 1'b0, '0, 10'd40, 1'b1, "");
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd41, 1'b1, "R1");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, 10'd41, 1'b1, "");
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd40, 1'b1, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0, '0, 10'd40, 1'b1, "");
    desel(2);
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd41, 1'b1, "R1");
    // R8 deselect ends a burst; advances afterwards stay idle
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd12, 1'b1, "");
    step(1'b0, 1'b0, 1'b1, 1'b1, '1, 10'd12, 1'b1, "R8");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1, 1'b0, '1, '0, 1'b1, "R8");
    // constrained random mix
    for (int k = 0; k < 3000; k++)
      step(($urandom % 10) == 0, $urandom % 2, $urandom % 2, ($urandom % 10) == 0,
           NB'($urandom), AW'($urandom % 64), $urandom % 2, "");
    desel(3);
    // R9 reset keeps the array
    do_reset();
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd5, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b1, 1'b0, '1, 10'd33, 1'b1, "R9");
    desel(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule